// File: doc/BRIEF.md
# Signed-Command PWM Pin Pair

This block turns a signed duty command into a pulse-width waveform on two physical pins. A free-running period counter sets the frame. The command's magnitude, clamped to the counter's full scale, gives how many counts each frame the pulse stays active. The sign decides which pin carries it. A new command is taken only when the counter wraps, so a frame never changes its width part way through.

A mode bit selects one of two ways to present the signed value. In split-pulse mode, pin 0 pulses for positive commands and pin 1 pulses for negative ones. In pulse-plus-sign mode, pin 0 carries the waveform and pin 1 carries the sign. Each pin then passes through an exclusive-OR with its own general-purpose output bit and its own polarity bit. A pin that the generator leaves idle can therefore be driven as a plain digital output, and any pin can be made active low.

Top module: `spwm_pair`

## Requirements
- R1: The period counter runs from 0 to 1023 and wraps, so one frame lasts 1024 clocks. Within a frame, the generated pulse is high from the first count while the count is below the latched magnitude.
- R2: The magnitude of the 11-bit two's complement command is clamped to 1023. A command of -1024 gives a pulse of 1023 counts, and +1023 gives 1023 counts.
- R3: The command is sampled only in the cycle in which the counter wraps. A change of `cmd_i` in the middle of a frame has no effect on the width of that frame at the pins.
- R4: With `mode_i` = 0 (split-pulse), a positive command pulses pin 0 and leaves pin 1 idle. A negative command pulses pin 1 and leaves pin 0 idle.
- R5: With `mode_i` = 1 (pulse-plus-sign), pin 0 carries the pulse for either sign. Pin 1 is high for the whole frame when the command is negative and low otherwise.
- R6: A zero command leaves both generated signals low for the whole frame in both modes.
- R7: Each pin is its generated signal XORed with its bit of `gpo_i` (bit 0 for pin 0, bit 1 for pin 1).
- R8: Each pin is further XORed with its bit of `inv_i` (bit 0 for pin 0, bit 1 for pin 1), which makes that pin active low.
- R9: During reset both pins are low. Counter and latched magnitude restart at zero, so the first frame after reset is idle.
- R10: With the default registered output stage, a pin shows the value for a counter state one clock after the counter holds that state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 11 | Signed duty command, two's complement |
| mode_i | input | 1 | 0 = split-pulse, 1 = pulse-plus-sign |
| inv_i | input | 2 | Per-pin polarity flip |
| gpo_i | input | 2 | Per-pin general-purpose output bit |
| pin_o | output | 2 | Physical pin levels |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that the polarity and general-purpose bits do not change in the same cycle as the generated signal they are meant to flip. The stimulus respects both. It moves `cmd_i` only halfway through a frame, so every command change also exercises the wrap-only sampling of R3. It moves mode, polarity and general-purpose bits only in the clock that starts a new frame, so each frame at the pins is produced by one fixed set of inputs. The bench counts high clocks per pin over each frame and checks the first clock of each frame against values computed from the requirements.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
   typedef enum logic {
      MODE_SPLIT   = 1'b0,
      MODE_PULSSGN = 1'b1
   } drive_mode_e;

   localparam int unsigned NUM_PINS = 2;
endpackage

// File: rtl/spwm_period_ctr.sv
module spwm_period_ctr #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = (cnt_q == CNT_MAX);

   // R1: counter steps by one and returns to zero after its top value
   p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX) |=> (cnt_q == '0));
   p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/spwm_cmd_latch.sv
module spwm_cmd_latch #(
   parameter int unsigned CMD_W = 11,
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wrap_i,
   input  logic [CMD_W-1:0] cmd_i,
   output logic [CNT_W-1:0] mag_o,
   output logic             neg_o
);
   localparam int unsigned CMP_W = (CMD_W > CNT_W) ? CMD_W : CNT_W + 1;
   localparam logic [CMP_W-1:0] SAT_MAX = CMP_W'({CNT_W{1'b1}});

   logic             sgn;
   logic [CMD_W-1:0] abs_v;
   logic [CMP_W-1:0] abs_x;
   logic [CNT_W-1:0] mag_next;
   logic [CNT_W-1:0] mag_q;
   logic             neg_q;

   always_comb begin
      sgn      = cmd_i[CMD_W-1];
      abs_v    = sgn ? (~cmd_i + 1'b1) : cmd_i;
      abs_x    = CMP_W'(abs_v);
      mag_next = (abs_x > SAT_MAX) ? SAT_MAX[CNT_W-1:0] : abs_x[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mag_q <= '0;
         neg_q <= 1'b0;
      end else if (wrap_i) begin
         mag_q <= mag_next;
         neg_q <= sgn;
      end
   end

   assign mag_o = mag_q;
   assign neg_o = neg_q;

   // R3: latched command only moves at the wrap
   p_hold_midframe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_i |=> ($stable(mag_q) && $stable(neg_q)));

   // R2: most negative command clamps to full scale
   if (CMD_W - 1 >= CNT_W) begin : g_sat_chk
      p_clamp_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (wrap_i && cmd_i == {1'b1, {(CMD_W-1){1'b0}}}) |=> (mag_q == {CNT_W{1'b1}}));
   end
endmodule

// File: rtl/spwm_steer.sv
module spwm_steer
   import spwm_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] mag_i,
   input  logic             neg_i,
   input  drive_mode_e      mode_i,
   output logic [1:0]       raw_o
);
   logic pulse;

   always_comb begin
      pulse = (cnt_i < mag_i);
      unique case (mode_i)
         MODE_PULSSGN: raw_o = {neg_i, pulse};
         default:      raw_o = {pulse & neg_i, pulse & ~neg_i};
      endcase
   end

   // R4: split-pulse mode never drives both pins
   p_split_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_SPLIT) |-> !(raw_o[0] && raw_o[1]));
   // R5: sign pin follows a negative command in pulse-plus-sign mode
   p_sign_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_PULSSGN && neg_i) |-> raw_o[1]);
   // R6: zero magnitude leaves both generated signals low
   p_zero_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mag_i == '0 && !neg_i) |-> (raw_o == 2'b00));
endmodule

// File: rtl/spwm_pin_stage.sv
module spwm_pin_stage #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] raw_i,
   input  logic [1:0] gpo_i,
   input  logic [1:0] inv_i,
   output logic [1:0] pin_o
);
   for (genvar gi = 0; gi < 2; gi++) begin : g_pin
      logic lvl;
      assign lvl = raw_i[gi] ^ gpo_i[gi] ^ inv_i[gi];

      if (OUT_REG) begin : g_reg
         logic pin_q;
         logic live_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pin_q  <= 1'b0;
               live_q <= 1'b0;
            end else begin
               pin_q  <= lvl;
               live_q <= 1'b1;
            end
         end
         assign pin_o[gi] = pin_q;

         // R7: toggling only the general-purpose bit toggles the pin next clock
         p_gpo_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && !$stable(gpo_i[gi]) && $stable(raw_i[gi]) && $stable(inv_i[gi]))
            |=> (pin_o[gi] != $past(pin_o[gi])));
         // R8: toggling only the polarity bit toggles the pin next clock
         p_inv_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && !$stable(inv_i[gi]) && $stable(raw_i[gi]) && $stable(gpo_i[gi]))
            |=> (pin_o[gi] != $past(pin_o[gi])));
      end else begin : g_comb
         assign pin_o[gi] = rst_n ? lvl : 1'b0;
      end
   end
endmodule

// File: rtl/spwm_pair.sv
module spwm_pair
   import spwm_pkg::*;
#(
   parameter int unsigned CMD_W   = 11,
   parameter int unsigned CNT_W   = 10,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMD_W-1:0] cmd_i,
   input  logic             mode_i,
   input  logic [1:0]       inv_i,
   input  logic [1:0]       gpo_i,
   output logic [1:0]       pin_o
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("spwm_pair: CNT_W must be at least 2");
   end
   if (CMD_W < 2) begin : g_bad_cmd
      $error("spwm_pair: CMD_W must be at least 2");
   end
   if (NUM_PINS != 2) begin : g_bad_pins
      $error("spwm_pair: pin stage is built for two pins");
   end

   logic [CNT_W-1:0] cnt;
   logic             wrap;
   logic [CNT_W-1:0] mag;
   logic             neg;
   logic [1:0]       raw;
   drive_mode_e      mode_e;

   assign mode_e = drive_mode_e'(mode_i);

   spwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .cnt_o(cnt), .wrap_o(wrap)
   );

   spwm_cmd_latch #(.CMD_W(CMD_W), .CNT_W(CNT_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .cmd_i(cmd_i),
      .mag_o(mag), .neg_o(neg)
   );

   spwm_steer #(.CNT_W(CNT_W)) u_steer (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .mag_i(mag), .neg_i(neg),
      .mode_i(mode_e), .raw_o(raw)
   );

   spwm_pin_stage #(.OUT_REG(OUT_REG)) u_pins (
      .clk(clk), .rst_n(rst_n), .raw_i(raw), .gpo_i(gpo_i), .inv_i(inv_i),
      .pin_o(pin_o)
   );

   // R9: pins stay low while reset is held
   p_reset_low_r9: assert property (@(posedge clk)
      !rst_n |=> (OUT_REG ? (pin_o == 2'b00) : 1'b1));
endmodule

// File: tb/sim_spwm_pair.sv
module sim_spwm_pair;
   localparam int FRAME = 1024;
   localparam int LAST_WIN = 11;

   typedef struct {
      int    hi_a;
      int    hi_b;
      bit    first_a;
      bit    first_b;
      string tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] cmd_i = '0;
   logic        mode_i = 1'b0;
   logic [1:0]  inv_i = '0;
   logic [1:0]  gpo_i = '0;
   logic [1:0]  pin_o;

   int n_checks = 0;
   int n_errors = 0;
   int n = 0;
   int acc_a = 0;
   int acc_b = 0;
   bit fa = 1'b0;
   bit fb = 1'b0;
   bit finished = 1'b0;
   exp_t q[$];
   exp_t e;

   always #4 clk = ~clk;

   spwm_pair u0 (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .mode_i(mode_i),
      .inv_i(inv_i), .gpo_i(gpo_i), .pin_o(pin_o)
   );

   always @(posedge clk) if (rst_n) n <= n + 1;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic exp_t model(input int cmd, input bit mode, input bit [1:0] inv,
                                  input bit [1:0] gpo, input string tag);
      exp_t r;
      int   m;
      bit   ng;
      int   ra, rb;
      ng = (cmd < 0);
      m  = ng ? -cmd : cmd;
      if (m > 1023) m = 1023;
      if (mode) begin
         ra = m;
         rb = ng ? FRAME : 0;
      end else begin
         ra = ng ? 0 : m;
         rb = ng ? m : 0;
      end
      r.first_a = (ra > 0) ^ gpo[0] ^ inv[0];
      r.first_b = (rb > 0) ^ gpo[1] ^ inv[1];
      r.hi_a    = (gpo[0] ^ inv[0]) ? FRAME - ra : ra;
      r.hi_b    = (gpo[1] ^ inv[1]) ? FRAME - rb : rb;
      r.tag     = tag;
      return r;
   endfunction

   // Driver: command mid-frame before window p, controls at the start of window p
   task automatic drive_win(input int p, input int cmd, input bit mode,
                            input bit [1:0] inv, input bit [1:0] gpo, input string tag);
      wait (n == FRAME * p - FRAME / 2);
      @(negedge clk);
      cmd_i = 11'(cmd);
      q.push_back(model(cmd, mode, inv, gpo, tag));
      wait (n == FRAME * p);
      @(negedge clk);
      mode_i = mode;
      inv_i  = inv;
      gpo_i  = gpo;
   endtask

   // Monitor: per-frame high counts at the pins (registered output: frame w ends at n = 1024*(w+1))
   always @(negedge clk) begin
      if (rst_n && n >= 1) begin
         int pos;
         pos = (n - 1) % FRAME;
         if (pos == 0) begin
            acc_a = 0;
            acc_b = 0;
            fa = pin_o[0];
            fb = pin_o[1];
         end
         acc_a += int'(pin_o[0]);
         acc_b += int'(pin_o[1]);
         if (pos == FRAME - 1) begin
            if (q.size() == 0) begin
               chk("R1", "missing expected frame", 0, 1);
            end else begin
               e = q.pop_front();
               chk(e.tag, "pin0 high clocks", acc_a, e.hi_a);
               chk(e.tag, "pin1 high clocks", acc_b, e.hi_b);
               chk(e.tag, "pin0 first clock", int'(fa), int'(e.first_a));
               chk(e.tag, "pin1 first clock", int'(fb), int'(e.first_b));
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20 * FRAME) @(posedge clk);
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog expired at frame %0d", n / FRAME);
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      q.push_back(model(0, 1'b0, 2'b00, 2'b00, "R9 R10 first frame idle"));
      repeat (3) @(negedge clk);
      chk("R9", "pins in reset", int'(pin_o), 0);
      rst_n = 1'b1;
      drive_win(1,   300, 1'b0, 2'b00, 2'b00, "R1 R4 R3 split positive");
      drive_win(2,  -200, 1'b0, 2'b00, 2'b00, "R4 R3 split negative");
      drive_win(3, -1024, 1'b0, 2'b00, 2'b00, "R2 clamp most negative");
      drive_win(4,  1023, 1'b1, 2'b00, 2'b00, "R5 R2 pulse-sign full positive");
      drive_win(5,   -77, 1'b1, 2'b00, 2'b00, "R5 pulse-sign negative");
      drive_win(6,     0, 1'b1, 2'b00, 2'b00, "R6 zero pulse-sign");
      drive_win(7,     0, 1'b0, 2'b00, 2'b10, "R6 R7 zero split gpo pin1");
      drive_win(8,   500, 1'b0, 2'b00, 2'b01, "R7 gpo on pulsing pin0");
      drive_win(9,  -600, 1'b0, 2'b10, 2'b00, "R8 invert pin1");
      drive_win(10,    1, 1'b1, 2'b11, 2'b01, "R7 R8 combined flips");
      drive_win(11, 1023, 1'b0, 2'b00, 2'b00, "R2 R1 full positive split");
      wait (n == FRAME * (LAST_WIN + 1) + 1);
      @(negedge clk);
      chk("R1", "frames left unchecked", q.size(), 0);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule